// File: doc/BRIEF.md
# USB Link Power Management Host Transmit and Resume Control

This block sits on the host side of a USB controller and handles two link power management actions. When software sets the transmit bit, it asks the bus engine to send an LPM token. It then waits for the device's reply. If the reply window expires, it asks again. After a set number of expired windows it gives up and reports an error. If a reply token comes back, it reports success.

Later, software sets the resume bit to wake the link from the L1 sleep state. The block then drives resume signalling for a length computed in hardware from the 4-bit host-initiated resume duration value (HIRD). Each HIRD unit adds a fixed number of clock cycles to a fixed base.

The token request toward the bus engine is a valid/ready stream of one-beat transfers. `lpm_req_valid` rises and then stays high, with no change, until the engine accepts it with `lpm_req_ready`. The engine may hold ready low for as long as it wants. A request counts as sent only on a cycle where both are high.

Top module: `usb_lpm_host_ctl`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x00 and `lpm_req_valid`, `resume_drive`, `xmt_done` and `xmt_err` are all low.
- R2: A register write with bit 0 set, while the link is idle, sets the transmit bit (bit 0 of `ctrl_rdata`) and raises `lpm_req_valid` on the next cycle. `lpm_req_valid` stays high while `lpm_req_ready` is low, and drops on the cycle after the handshake.
- R3: A `tok_rx` pulse while the transmit bit is set clears bit 0 on the next cycle. On that same cycle `xmt_done` is high for exactly one cycle.
- R4: A `rsp_timeout` pulse after the handshake, when fewer than MAX_TIMEOUTS (default 3) timeouts have been counted for this request, raises `lpm_req_valid` again on the next cycle as a retry. Bit 0 stays set.
- R5: The MAX_TIMEOUTS-th timeout clears bit 0 on the next cycle. On that same cycle `xmt_err` is high for exactly one cycle. The timeout count restarts at zero for every new transmit request.
- R6: A write of bit 0 while a transmission is still in progress has no effect: it does not restart the request and does not reset the timeout count.
- R7: A write with bit 1 set while `link_in_l1` is high, and while no resume is running, sets bit 1 of `ctrl_rdata` and holds `resume_drive` high for exactly BASE_CYC + HIRD × STEP_CYC cycles. HIRD is taken from `hird` at the write. Bit 1 clears on the cycle `resume_drive` falls.
- R8: A write of bit 1 while `link_in_l1` is low, or while a resume is already running, is ignored.
- R9: Bits 7:2 of `ctrl_rdata` always read 0, and writing ones to them starts nothing.
- R10: `tok_rx` and `rsp_timeout` pulses while no transmission is in progress raise neither strobe and change no bit. `rsp_timeout` while the request is still awaiting its handshake is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data (bit 0 transmit, bit 1 resume) |
| ctrl_rdata | output | 8 | Control register read value |
| hird | input | 4 | Resume duration field from the attribute register |
| link_in_l1 | input | 1 | Link currently in the L1 state |
| lpm_req_valid | output | 1 | Request to send the LPM token |
| lpm_req_ready | input | 1 | Bus engine accepts the token request |
| tok_rx | input | 1 | Pulse: a response token was received |
| rsp_timeout | input | 1 | Pulse: the response window expired |
| resume_drive | output | 1 | Drive resume signalling on the bus |
| xmt_done | output | 1 | One-cycle strobe: LPM transmission answered |
| xmt_err | output | 1 | One-cycle strobe: LPM transmission abandoned after the timeout limit |

## Verification
The hardest situation to reach is the abandon path after the third timeout. It needs two full retry rounds, each with a handshake and a timeout, and the timeouts must land after the handshake, because a timeout before the handshake is not counted. The stimulus stalls `lpm_req_ready` to exercise back-pressure and checks each retry before it fires the next timeout. It also sends a stray transmit write partway through, to show the count is not reset. A fresh request then receives the full allowance of three timeouts again. The resume length is checked with small parameter values, by counting the cycles in which `resume_drive` is high for two different HIRD values.

// File: rtl/usb_lpm_host_pkg.sv
package usb_lpm_host_pkg;
  localparam int CTRL_W       = 8;
  localparam int CTRL_XMT_BIT = 0;
  localparam int CTRL_RES_BIT = 1;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xmt_state_e;
endpackage

// File: rtl/usb_lpm_xmt_fsm.sv
module usb_lpm_xmt_fsm
  import usb_lpm_host_pkg::*;
#(
  parameter int MAX_TIMEOUTS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tok_rx,
  input  logic rsp_timeout,
  output logic req_valid,
  input  logic req_ready,
  output logic busy,
  output logic done_stb,
  output logic err_stb
);
  localparam int TW = (MAX_TIMEOUTS < 2) ? 1 : $clog2(MAX_TIMEOUTS);
  localparam logic [TW-1:0] LAST_TMO = TW'(MAX_TIMEOUTS - 1);

  xmt_state_e      state_q;
  logic [TW-1:0]   tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= XS_IDLE;
      tmo_q    <= '0;
      done_stb <= 1'b0;
      err_stb  <= 1'b0;
    end else begin
      done_stb <= 1'b0;
      err_stb  <= 1'b0;
      unique case (state_q)
        XS_IDLE: begin
          if (start) begin
            state_q <= XS_REQ;
            tmo_q   <= '0;
          end
        end
        XS_REQ: begin
          if (tok_rx) begin
            state_q  <= XS_IDLE;
            done_stb <= 1'b1;
          end else if (req_ready) begin
            state_q <= XS_WAIT;
          end
        end
        XS_WAIT: begin
          if (tok_rx) begin
            state_q  <= XS_IDLE;
            done_stb <= 1'b1;
          end else if (rsp_timeout) begin
            if (tmo_q == LAST_TMO) begin
              state_q <= XS_IDLE;
              err_stb <= 1'b1;
            end else begin
              tmo_q   <= tmo_q + 1'b1;
              state_q <= XS_REQ;
            end
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign req_valid = (state_q == XS_REQ);
  assign busy      = (state_q != XS_IDLE);
endmodule

// File: rtl/usb_lpm_resume_timer.sv
module usb_lpm_resume_timer #(
  parameter int BASE_CYC = 10000,
  parameter int STEP_CYC = 15000,
  parameter int HIRD_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HIRD_W-1:0] hird,
  output logic              active
);
  localparam int MAX_LEN = BASE_CYC + ((1 << HIRD_W) - 1) * STEP_CYC;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_len;

  assign load_len = CW'(BASE_CYC) + CW'(hird) * CW'(STEP_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (!active) begin
      if (start) begin
        cnt_q  <= load_len;
        active <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) active <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_lpm_host_ctl.sv
module usb_lpm_host_ctl
  import usb_lpm_host_pkg::*;
#(
  parameter int BASE_CYC     = 10000,
  parameter int STEP_CYC     = 15000,
  parameter int MAX_TIMEOUTS = 3,
  parameter int HIRD_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic [HIRD_W-1:0] hird,
  input  logic              link_in_l1,
  output logic              lpm_req_valid,
  input  logic              lpm_req_ready,
  input  logic              tok_rx,
  input  logic              rsp_timeout,
  output logic              resume_drive,
  output logic              xmt_done,
  output logic              xmt_err
);
  logic xmt_busy;
  logic xmt_start;
  logic res_start;

  assign xmt_start = reg_wr && reg_wdata[CTRL_XMT_BIT];
  assign res_start = reg_wr && reg_wdata[CTRL_RES_BIT] && link_in_l1;

  usb_lpm_xmt_fsm #(
    .MAX_TIMEOUTS(MAX_TIMEOUTS)
  ) i_xmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (xmt_start),
    .tok_rx     (tok_rx),
    .rsp_timeout(rsp_timeout),
    .req_valid  (lpm_req_valid),
    .req_ready  (lpm_req_ready),
    .busy       (xmt_busy),
    .done_stb   (xmt_done),
    .err_stb    (xmt_err)
  );

  usb_lpm_resume_timer #(
    .BASE_CYC(BASE_CYC),
    .STEP_CYC(STEP_CYC),
    .HIRD_W  (HIRD_W)
  ) i_res (
    .clk   (clk),
    .rst_n (rst_n),
    .start (res_start),
    .hird  (hird),
    .active(resume_drive)
  );

  always_comb begin
    ctrl_rdata               = '0;
    ctrl_rdata[CTRL_XMT_BIT] = xmt_busy;
    ctrl_rdata[CTRL_RES_BIT] = resume_drive;
  end
endmodule

// File: rtl/usb_lpm_host_chk.sv
module usb_lpm_host_chk #(
  parameter int BASE_CYC = 10000,
  parameter int STEP_CYC = 15000,
  parameter int HIRD_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        ctrl_rdata,
  input logic [HIRD_W-1:0] hird,
  input logic              link_in_l1,
  input logic              lpm_req_valid,
  input logic              lpm_req_ready,
  input logic              tok_rx,
  input logic              rsp_timeout,
  input logic              resume_drive,
  input logic              xmt_done,
  input logic              xmt_err
);
  int unsigned run_cnt;
  int unsigned exp_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= 0;
      exp_len <= 0;
    end else if (resume_drive) begin
      run_cnt <= run_cnt + 1;
      if (run_cnt == 0) exp_len <= BASE_CYC + int'(hird) * STEP_CYC;
    end else begin
      run_cnt <= 0;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lpm_req_valid && !lpm_req_ready && !tok_rx |=> lpm_req_valid);

  // R3
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmt_done |-> $past(tok_rx));

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmt_err |-> $past(rsp_timeout) && !xmt_done);

  // R3
  xmt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rdata[0]) |-> (xmt_done || xmt_err));

  // R8
  resume_l1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_drive) |-> $past(link_in_l1));

  // R7
  resume_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resume_drive) |-> run_cnt == exp_len);

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[7:2] == 6'd0);
endmodule

bind usb_lpm_host_ctl usb_lpm_host_chk #(
  .BASE_CYC(BASE_CYC),
  .STEP_CYC(STEP_CYC),
  .HIRD_W  (HIRD_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_rdata   (ctrl_rdata),
  .hird         (hird),
  .link_in_l1   (link_in_l1),
  .lpm_req_valid(lpm_req_valid),
  .lpm_req_ready(lpm_req_ready),
  .tok_rx       (tok_rx),
  .rsp_timeout  (rsp_timeout),
  .resume_drive (resume_drive),
  .xmt_done     (xmt_done),
  .xmt_err      (xmt_err)
);

// File: tb/test_usb_lpm_host_ctl.sv
`timescale 1ns/1ps
module test_usb_lpm_host_ctl;
  localparam int BASE = 20;
  localparam int STEP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic [3:0] hird = '0;
  logic       link_in_l1 = 1'b0;
  logic       lpm_req_valid;
  logic       lpm_req_ready = 1'b0;
  logic       tok_rx = 1'b0;
  logic       rsp_timeout = 1'b0;
  logic       resume_drive;
  logic       xmt_done;
  logic       xmt_err;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  usb_lpm_host_ctl #(
    .BASE_CYC(BASE),
    .STEP_CYC(STEP),
    .MAX_TIMEOUTS(3),
    .HIRD_W(4)
  ) i_usb_lpm_host_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctrl_rdata(ctrl_rdata), .hird(hird), .link_in_l1(link_in_l1),
    .lpm_req_valid(lpm_req_valid), .lpm_req_ready(lpm_req_ready),
    .tok_rx(tok_rx), .rsp_timeout(rsp_timeout), .resume_drive(resume_drive),
    .xmt_done(xmt_done), .xmt_err(xmt_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_tok();
    tok_rx = 1'b1; @(negedge clk); tok_rx = 1'b0;
  endtask

  task automatic pulse_tmo();
    rsp_timeout = 1'b1; @(negedge clk); rsp_timeout = 1'b0;
  endtask

  task automatic handshake();
    lpm_req_ready = 1'b1; @(negedge clk); lpm_req_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "ctrl_rdata", ctrl_rdata, 0);
    check("R1", "valid", lpm_req_valid, 0);
    check("R1", "resume_drive", resume_drive, 0);
    check("R1", "strobes", {xmt_done, xmt_err}, 0);
  endtask

  task automatic t_xmt_ok();
    wr(8'h01);
    check("R2", "xmt bit set", ctrl_rdata[0], 1);
    check("R2", "valid raised", lpm_req_valid, 1);
    repeat (3) @(negedge clk);
    check("R2", "valid held under back-pressure", lpm_req_valid, 1);
    handshake();
    check("R2", "valid dropped after handshake", lpm_req_valid, 0);
    check("R2", "bit stays while waiting", ctrl_rdata[0], 1);
    pulse_tok();
    check("R3", "bit cleared on token", ctrl_rdata[0], 0);
    check("R3", "done strobe", xmt_done, 1);
    check("R3", "no err", xmt_err, 0);
    @(negedge clk);
    check("R3", "done one cycle", xmt_done, 0);
  endtask

  task automatic t_xmt_timeouts();
    wr(8'h01);
    pulse_tmo();
    check("R10", "early timeout not counted", lpm_req_valid, 1);
    handshake();
    pulse_tmo();
    check("R4", "retry after first timeout", lpm_req_valid, 1);
    check("R4", "bit stays", ctrl_rdata[0], 1);
    wr(8'h01);
    handshake();
    pulse_tmo();
    check("R6", "stray write kept count; retry 2", lpm_req_valid, 1);
    handshake();
    pulse_tmo();
    check("R5", "bit cleared after 3rd timeout", ctrl_rdata[0], 0);
    check("R5", "err strobe", xmt_err, 1);
    check("R5", "no done", xmt_done, 0);
    @(negedge clk);
    check("R5", "err one cycle", xmt_err, 0);
    wr(8'h01);
    handshake(); pulse_tmo();
    handshake(); pulse_tmo();
    check("R5", "fresh count: still busy after 2", ctrl_rdata[0], 1);
    handshake(); pulse_tmo();
    check("R5", "fresh count: err on 3rd", xmt_err, 1);
  endtask

  task automatic t_idle_noise();
    @(negedge clk);
    pulse_tok();
    check("R10", "token in idle no strobe", {xmt_done, xmt_err}, 0);
    pulse_tmo();
    check("R10", "timeout in idle no strobe", {xmt_done, xmt_err}, 0);
    check("R10", "bits unchanged", ctrl_rdata, 0);
    wr(8'hFC);
    check("R9", "reserved write starts nothing", ctrl_rdata, 0);
    check("R9", "no request", lpm_req_valid, 0);
  endtask

  task automatic t_resume(input logic [3:0] h);
    int n = 0;
    hird = h;
    link_in_l1 = 1'b1;
    wr(8'h02);
    check("R7", "res bit set", ctrl_rdata[1], 1);
    while (resume_drive && n < 1000) begin
      if (n == 5) begin
        wr(8'h02);
        n++;
      end else begin
        @(negedge clk);
        n++;
      end
    end
    check("R7", $sformatf("resume length hird=%0d", h), n, BASE + h * STEP);
    check("R7", "res bit cleared", ctrl_rdata[1], 0);
    @(negedge clk);
    check("R8", "write during resume not restarted", resume_drive, 0);
    link_in_l1 = 1'b0;
  endtask

  task automatic t_resume_not_l1();
    link_in_l1 = 1'b0;
    wr(8'h02);
    check("R8", "ignored outside L1", resume_drive, 0);
    check("R8", "bit stays 0", ctrl_rdata[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xmt_ok();
    t_xmt_timeouts();
    t_idle_noise();
    t_resume(4'd5);
    t_resume(4'd15);
    t_resume_not_l1();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule